// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs external memory cycles for a small processor core over one set of 16 shared pins. In each cycle the pins carry the address first and then the data. An internal request port supplies the address, the write data, the access size (byte or word) and the direction. The controller then steps through an address phase, an address hold clock and a data phase, and ends with a one-clock done pulse. Read data is valid during that pulse.

The controller produces these strobes:
- a one-clock latch-enable strobe, so an external latch can capture the address;
- an active-low address-valid strobe, which stays low for the whole bus cycle;
- active-low read and write strobes.

A 2-bit wait count, captured when the request is accepted, stretches the data phase. The bus width has three settings: fixed 8-bit, fixed 16-bit, or dynamic, where a side input picks the width for each access. In 8-bit mode a word access becomes two byte cycles, low byte first. While no access is in progress, the pins carry the general-purpose port's output value and output enables unchanged.

Top module: `muxbus_ctrl`

## Requirements
- R1: While in reset, and whenever `busy` is low, `pad_out`/`pad_oe` equal `port_out`/`port_oe`, `ale` is 0, and `adv_n`, `rd_n` and `wr_n` are 1.
- R2: A request seen with `req_valid` high while idle is accepted at that clock edge. In the next clock `ale` is 1 for exactly that one clock and the pins drive the full 16-bit address with `pad_oe` all ones. The following clock keeps the same address on the pins with `ale` at 0.
- R3: `adv_n` is 0 from the `ale` clock through the last data clock of each bus cycle. It is 1 in every other clock, including the single gap clock between the two halves of a split access.
- R4: In a write data phase `wr_n` is 0. A 16-bit transfer drives all pins with `pad_oe` = 16'hFFFF. An 8-bit transfer drives its byte on `pad_out[7:0]` with `pad_oe` = 16'h00FF.
- R5: In a read data phase `rd_n` is 0 and `pad_oe` is 0. `pad_in` is sampled on the last data clock. A byte read returns `pad_in[7:0]` zero-extended.
- R6: The data phase lasts 1 + W clocks, where W is `wait_cfg` captured at acceptance. Later changes to `wait_cfg` have no effect on the access in progress.
- R7: `bw_mode` selects the bus width at acceptance: 0 is fixed 8-bit, 1 is fixed 16-bit, 2 is dynamic (`dyn_wide` = 1 means 16-bit, 0 means 8-bit), and 3 behaves as 1. Byte requests always use 8-bit transfers.
- R8: A word request on an 8-bit bus runs two byte cycles. The first carries the low byte at the request address. The second carries the high byte at address + 1, wrapping modulo 2^16. Between them is one gap clock with `pad_oe` = 0 and `busy` still 1.
- R9: `done` is 1 for exactly one clock, the clock after the last data clock. `rdata` is valid in that clock. `busy` is 1 from the address phase through the last data clock, and 0 in the done clock. A new request presented in the done clock is accepted.
- R10: Requests presented while `busy` is 1 are ignored: the pins and strobes of the access in progress are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| bw_mode | input | 2 | Width mode: 0 fixed 8, 1 fixed 16, 2 dynamic, 3 as 1 |
| dyn_wide | input | 1 | Per-access width in dynamic mode (1 = 16-bit) |
| wait_cfg | input | 2 | Wait states for the data phase |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read result |
| port_out | input | 16 | Port output value used while idle |
| port_oe | input | 16 | Port output enables used while idle |
| pad_in | input | 16 | Value seen on the shared pins |
| pad_out | output | 16 | Value driven onto the shared pins |
| pad_oe | output | 16 | Per-pin output enable |
| ale | output | 1 | Address latch strobe |
| adv_n | output | 1 | Active-low address valid |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The bench targets the following corner cases:
- A split word access at address 16'hFFFF. An address incrementer that does not wrap, or that updates before the gap clock, puts the wrong second address on the pins.
- Wait counts of 0 and 3. An off-by-one in the data-phase counter moves the read sample clock, which returns a neighbouring pattern, or it shortens the write strobe.
- Requests, width modes and wait counts changed while busy. A design that reacts to them, instead of holding its captured values, corrupts the cycle in progress.
- Back-to-back requests issued in the done clock. A controller that idles one extra clock shows up as a shifted trace.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_DATA = 3'd3,
    ST_GAP  = 3'd4
  } bus_state_e;

  typedef enum logic [1:0] {
    BW_FIX8  = 2'd0,
    BW_FIX16 = 2'd1,
    BW_DYN   = 2'd2,
    BW_RSVD  = 2'd3
  } width_mode_e;

endpackage

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [1:0]        bw_mode,
  input  logic              dyn_wide,
  input  logic [WAIT_W-1:0] wait_cfg,
  output bus_state_e        state,
  output logic              accept,
  output logic              half,
  output logic              xfer16,
  output logic              write_q,
  output logic              last_data,
  output logic              done,
  output logic              busy
);

  bus_state_e        st_q, st_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d, wlat_q, wlat_d;
  logic              half_q, half_d, split_q, split_d;
  logic              x16_q, x16_d, wr_q, wr_d, done_q, done_d;
  logic              wide;

  // width chosen for this access
  always_comb begin
    case (width_mode_e'(bw_mode))
      BW_FIX8: wide = 1'b0;
      BW_DYN:  wide = dyn_wide;
      default: wide = 1'b1;
    endcase
  end

  assign accept    = (st_q == ST_IDLE) && req_valid;
  assign last_data = (st_q == ST_DATA) && (wcnt_q == '0);

  always_comb begin
    st_d    = st_q;
    wcnt_d  = wcnt_q;
    wlat_d  = wlat_q;
    half_d  = half_q;
    split_d = split_q;
    x16_d   = x16_q;
    wr_d    = wr_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_ADDR;
          wr_d    = req_write;
          x16_d   = req_word & wide;
          split_d = req_word & ~wide;
          wlat_d  = wait_cfg;
          half_d  = 1'b0;
        end
      end
      ST_ADDR: st_d = ST_HOLD;
      ST_HOLD: begin
        st_d   = ST_DATA;
        wcnt_d = wlat_q;
      end
      ST_DATA: begin
        if (wcnt_q != '0) begin
          wcnt_d = wcnt_q - WAIT_W'(1);
        end else if (split_q && !half_q) begin
          st_d   = ST_GAP;
          half_d = 1'b1;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      ST_GAP:  st_d = ST_ADDR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wcnt_q  <= '0;
      wlat_q  <= '0;
      half_q  <= 1'b0;
      split_q <= 1'b0;
      x16_q   <= 1'b0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      wcnt_q  <= wcnt_d;
      wlat_q  <= wlat_d;
      half_q  <= half_d;
      split_q <= split_d;
      x16_q   <= x16_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
    end
  end

  assign state   = st_q;
  assign half    = half_q;
  assign xfer16  = x16_q;
  assign write_q = wr_q;
  assign done    = done_q;
  assign busy    = (st_q != ST_IDLE);

endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          last_data,
  input  logic          half,
  input  logic          xfer16,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] addr_cur,
  output logic [DW-1:0] wdata_cur,
  output logic [DW-1:0] rdata
);

  localparam int BW = DW / 2;

  logic [DW-1:0] addr_q, wdata_q, rdata_q, rdata_d;

  always_comb begin
    if (xfer16)
      rdata_d = pad_in;
    else if (half)
      rdata_d = {pad_in[BW-1:0], rdata_q[BW-1:0]};
    else
      rdata_d = {{(DW-BW){1'b0}}, pad_in[BW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= '0;
    else if (last_data)
      rdata_q <= rdata_d;
  end

  // second half of a split access targets the next byte address
  assign addr_cur = addr_q + DW'(half);

  always_comb begin
    if (xfer16)
      wdata_cur = wdata_q;
    else if (half)
      wdata_cur = {{(DW-BW){1'b0}}, wdata_q[DW-1:BW]};
    else
      wdata_cur = {{(DW-BW){1'b0}}, wdata_q[BW-1:0]};
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/muxbus_padmux.sv
module muxbus_padmux
  import muxbus_pkg::*;
#(
  parameter int DW = 16
) (
  input  bus_state_e    state,
  input  logic          write_q,
  input  logic          xfer16,
  input  logic [DW-1:0] addr_cur,
  input  logic [DW-1:0] wdata_cur,
  input  logic [DW-1:0] port_out,
  input  logic [DW-1:0] port_oe,
  output logic [DW-1:0] pad_out,
  output logic [DW-1:0] pad_oe,
  output logic          ale,
  output logic          adv_n,
  output logic          rd_n,
  output logic          wr_n
);

  localparam int            BW      = DW / 2;
  localparam logic [DW-1:0] LO_LANE = {{(DW-BW){1'b0}}, {BW{1'b1}}};

  always_comb begin
    pad_out = '0;
    pad_oe  = '0;
    ale     = 1'b0;
    adv_n   = 1'b1;
    rd_n    = 1'b1;
    wr_n    = 1'b1;
    case (state)
      ST_IDLE: begin
        pad_out = port_out;
        pad_oe  = port_oe;
      end
      ST_ADDR: begin
        ale     = 1'b1;
        adv_n   = 1'b0;
        pad_out = addr_cur;
        pad_oe  = '1;
      end
      ST_HOLD: begin
        adv_n   = 1'b0;
        pad_out = addr_cur;
        pad_oe  = '1;
      end
      ST_DATA: begin
        adv_n = 1'b0;
        if (write_q) begin
          wr_n    = 1'b0;
          pad_out = wdata_cur;
          pad_oe  = xfer16 ? '1 : LO_LANE;
        end else begin
          rd_n = 1'b0;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int DW     = 16,
  parameter int WAIT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [DW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [1:0]        bw_mode,
  input  logic              dyn_wide,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  input  logic [DW-1:0]     port_out,
  input  logic [DW-1:0]     port_oe,
  input  logic [DW-1:0]     pad_in,
  output logic [DW-1:0]     pad_out,
  output logic [DW-1:0]     pad_oe,
  output logic              ale,
  output logic              adv_n,
  output logic              rd_n,
  output logic              wr_n
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  bus_state_e    state;
  logic          accept, half, xfer16, write_q, last_data;
  logic [DW-1:0] addr_cur, wdata_cur;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  muxbus_seq #(.WAIT_W(WAIT_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_word  (req_word),
    .bw_mode   (bw_mode),
    .dyn_wide  (dyn_wide),
    .wait_cfg  (wait_cfg),
    .state     (state),
    .accept    (accept),
    .half      (half),
    .xfer16    (xfer16),
    .write_q   (write_q),
    .last_data (last_data),
    .done      (done),
    .busy      (busy)
  );

  muxbus_dpath #(.DW(DW)) i_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .last_data (last_data),
    .half      (half),
    .xfer16    (xfer16),
    .pad_in    (pad_in),
    .addr_cur  (addr_cur),
    .wdata_cur (wdata_cur),
    .rdata     (rdata)
  );

  muxbus_padmux #(.DW(DW)) i_padmux (
    .state     (state),
    .write_q   (write_q),
    .xfer16    (xfer16),
    .addr_cur  (addr_cur),
    .wdata_cur (wdata_cur),
    .port_out  (port_out),
    .port_oe   (port_oe),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .ale       (ale),
    .adv_n     (adv_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

endmodule

// File: rtl/muxbus_ctrl_chk.sv
module muxbus_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ale,
  input logic          adv_n,
  input logic          rd_n,
  input logic          wr_n,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] pad_oe,
  input logic [DW-1:0] pad_out,
  input logic [DW-1:0] port_oe
);

  logic [2:0] strobe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      strobe_run <= '0;
    else if (!rd_n || !wr_n)
      strobe_run <= strobe_run + 3'd1;
    else
      strobe_run <= '0;
  end

  AST_IDLE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pad_oe == port_oe && ale == 1'b0 && adv_n && rd_n && wr_n)); // R1

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> $stable(pad_out)); // R2

  AST_ALE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!adv_n && busy)); // R3

  AST_STROBE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> !adv_n); // R3

  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (pad_oe == '0 && wr_n)); // R5

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (strobe_run < 3'd4)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && adv_n)); // R9

endmodule

bind muxbus_ctrl muxbus_ctrl_chk #(.DW(DW)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ale     (ale),
  .adv_n   (adv_n),
  .rd_n    (rd_n),
  .wr_n    (wr_n),
  .busy    (busy),
  .done    (done),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .port_oe (port_oe)
);

// File: tb/test_muxbus_ctrl.sv
module test_muxbus_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_word, dyn_wide;
  logic [15:0] req_addr, req_wdata, port_out, port_oe, pad_in;
  logic [1:0]  bw_mode, wait_cfg;
  logic        busy, done, ale, adv_n, rd_n, wr_n;
  logic [15:0] rdata, pad_out, pad_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  muxbus_ctrl i_muxbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .bw_mode(bw_mode), .dyn_wide(dyn_wide), .wait_cfg(wait_cfg),
    .busy(busy), .done(done), .rdata(rdata), .port_out(port_out),
    .port_oe(port_oe), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .ale(ale), .adv_n(adv_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  typedef struct packed {
    logic        ale, adv_n, rd_n, wr_n, busy, done;
    logic [15:0] oe, out;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;

  // external memory pattern: a function of the latched address
  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  logic [15:0] lat;
  always @(negedge clk) if (ale) lat <= pad_out;
  assign pad_in = memf(lat);

  function automatic exp_t mk(input logic a, input logic v, input logic r, input logic w,
                              input logic b, input logic d, input logic [15:0] oe,
                              input logic [15:0] o);
    exp_t e;
    e.ale = a; e.adv_n = v; e.rd_n = r; e.wr_n = w; e.busy = b; e.done = d;
    e.oe = oe; e.out = o;
    return e;
  endfunction

  task automatic check_entry(input exp_t e, input string tag);
    n_run++;
    if (ale !== e.ale || adv_n !== e.adv_n || rd_n !== e.rd_n || wr_n !== e.wr_n ||
        busy !== e.busy || done !== e.done || pad_oe !== e.oe ||
        (pad_out & e.oe) !== (e.out & e.oe)) begin
      n_fail++;
      $display("FAIL %s: got ale=%b adv_n=%b rd_n=%b wr_n=%b busy=%b done=%b oe=%h out=%h, exp ale=%b adv_n=%b rd_n=%b wr_n=%b busy=%b done=%b oe=%h out=%h",
               tag, ale, adv_n, rd_n, wr_n, busy, done, pad_oe, pad_out & e.oe,
               e.ale, e.adv_n, e.rd_n, e.wr_n, e.busy, e.done, e.oe, e.out & e.oe);
    end
  endtask

  // one bus cycle: address, hold, data phase of 1+w clocks
  task automatic push_cycle(input bit wr, input bit x16, input logic [15:0] a,
                            input logic [15:0] d, input int w);
    exp_q.push_back(mk(1, 0, 1, 1, 1, 0, 16'hFFFF, a));
    exp_q.push_back(mk(0, 0, 1, 1, 1, 0, 16'hFFFF, a));
    for (int i = 0; i <= w; i++) begin
      if (wr) exp_q.push_back(mk(0, 0, 1, 0, 1, 0, x16 ? 16'hFFFF : 16'h00FF, d));
      else    exp_q.push_back(mk(0, 0, 0, 1, 1, 0, 16'h0000, 16'h0000));
    end
  endtask

  task automatic xfer(input bit wr, input bit word, input logic [15:0] a,
                      input logic [15:0] wd, input logic [1:0] mode, input bit dyn,
                      input logic [1:0] w, input bit spur, input string tag);
    bit          wide, x16, split;
    logic [15:0] m0, m1, exp_rd, a1;
    exp_t        e;
    wide  = (mode == 2'd0) ? 1'b0 : (mode == 2'd2) ? dyn : 1'b1;
    x16   = word & wide;
    split = word & ~wide;
    a1    = a + 16'd1;
    m0    = memf(a);
    m1    = memf(a1);
    exp_rd = x16 ? m0 : split ? {m1[7:0], m0[7:0]} : {8'h00, m0[7:0]};
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
    bw_mode = mode; dyn_wide = dyn; wait_cfg = w;
    if (x16) push_cycle(wr, 1'b1, a, wd, int'(w));
    else     push_cycle(wr, 1'b0, a, {8'h00, wd[7:0]}, int'(w));
    if (split) begin
      exp_q.push_back(mk(0, 1, 1, 1, 1, 0, 16'h0000, 16'h0000));
      push_cycle(wr, 1'b0, a1, {8'h00, wd[15:8]}, int'(w));
    end
    exp_q.push_back(mk(0, 1, 1, 1, 0, 1, port_oe, port_out));
    @(negedge clk);
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      check_entry(e, tag);
      if (e.done && !wr) begin
        n_run++;
        if (rdata !== exp_rd) begin
          n_fail++;
          $display("FAIL %s rdata (R5 R9): got %h exp %h", tag, rdata, exp_rd);
        end
      end
      if (spur && exp_q.size() > 1) begin
        // R10: disturbing inputs while busy must change nothing
        req_addr = ~a; req_write = ~wr; req_word = ~word;
        wait_cfg = ~w; bw_mode = mode ^ 2'b01; dyn_wide = ~dyn;
      end else begin
        req_valid = 1'b0;
      end
      if (exp_q.size() > 0) @(negedge clk);
    end
  endtask

  task automatic idle_run(input int n, input logic [15:0] po, input logic [15:0] poe,
                          input string tag);
    port_out = po; port_oe = poe; req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_entry(mk(0, 1, 1, 1, 0, 0, poe, po), tag);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_word = 1'b0;
    req_addr = '0; req_wdata = '0; bw_mode = 2'd1; dyn_wide = 1'b0; wait_cfg = '0;
    port_out = 16'hA55A; port_oe = 16'h0F0F;
    idle_run(3, 16'hA55A, 16'h0F0F, "R1 in reset");
    rst_n = 1'b1;
    idle_run(4, 16'h1234, 16'hFFF0, "R1 idle after reset");

    xfer(1, 1, 16'h1200, 16'hBEEF, 2'd1, 0, 2'd0, 0, "R2 R3 R4 fixed16 word write");
    xfer(0, 1, 16'h4321, 16'h0000, 2'd1, 0, 2'd2, 0, "R5 R6 fixed16 word read w2");
    xfer(0, 0, 16'h00F3, 16'h0000, 2'd3, 0, 2'd1, 0, "R5 R7 mode3 byte read");
    xfer(1, 1, 16'h2000, 16'hCAFE, 2'd0, 0, 2'd0, 0, "R8 R4 fixed8 split write");
    xfer(0, 1, 16'h3456, 16'h0000, 2'd0, 0, 2'd3, 0, "R8 R6 fixed8 split read w3");
    idle_run(2, 16'h0F0F, 16'h00FF, "R1 idle between");
    xfer(1, 0, 16'h7701, 16'h9911, 2'd0, 0, 2'd1, 0, "R4 R7 fixed8 byte write");
    xfer(0, 1, 16'h5A5A, 16'h0000, 2'd2, 1, 2'd0, 0, "R7 dynamic wide read");
    xfer(1, 1, 16'h6000, 16'h1357, 2'd2, 0, 2'd2, 1, "R7 R10 dynamic narrow write busy");
    xfer(0, 1, 16'hFFFF, 16'h0000, 2'd0, 0, 2'd1, 0, "R8 split wrap read");
    xfer(0, 1, 16'h0ABC, 16'h0000, 2'd1, 0, 2'd3, 1, "R6 R10 fixed16 read busy");
    xfer(1, 0, 16'h8001, 16'h00C3, 2'd1, 0, 2'd0, 0, "R9 back to back byte write");
    idle_run(3, 16'h5555, 16'hAAAA, "R1 R9 idle after done");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule